// File: doc/BRIEF.md
# Serial Command and Data Port for a Clock/Calendar

This block is the host-facing side of a real-time clock. A host microcontroller picks an operation with three parallel command lines and a strobe, then moves a full time and date image through a 48-bit shift register. It clocks that register with its own serial clock, which counts only while chip select is asserted. All host pins are asynchronous to the block clock and pass through a synchroniser first.

The latched command selects one of these operations:
- **Hold:** freezes the counter chain.
- **Shift:** lets the serial clock move data.
- **Time set:** hands the register contents to the counters as a one-cycle preset.
- **Time read:** copies the counter image into the register after a fixed delay, so it can be shifted out.

When the command lines carry the all-ones pattern, the four-bit command is taken instead from the top nibble of the shift register. This extends the command space beyond the pins. The serial output only ever pulls low, as an open drain.

The frame is LSB first: seconds [7:0], minutes [15:8], hours [23:16], day [31:24], weekday [35:32], month [39:36], year [47:40]. The counter chain and the pulse generator sit outside the block. They connect through `cnt_i`, `preset_o`, `preset_valid_o`, `hold_o` and `cmd_o`.

Top module: `rtc_serial_port`

## Requirements
- R1: After reset, `cmd_o` is 0, `hold_o` is 1, `preset_valid_o` is 0, `sdo_pull_o` is 0 and `preset_o` is all zeros.
- R2: A rising strobe while chip select is high loads `cmd_o` with {0, cmd_i} for pin codes 0 to 6. A strobe while chip select is low leaves `cmd_o` unchanged.
- R3: A strobe with cmd_i = 3'b111 loads `cmd_o` with shift register bits [47:44].
- R4: In shift mode (code 1) or in read mode once its load is done (code 3), each rising serial clock with chip select high shifts right. The serial input enters bit 47 and bit 0 leaves. After 48 clocks the register holds the bits sent, first bit at bit 0.
- R5: The register is unchanged by serial clocks while chip select is low, and by serial clocks under any code other than 1 or 3.
- R6: `sdo_pull_o` is 1 exactly when chip select is high, the code permits shifting, and register bit 0 is 0. It is 0 otherwise (released).
- R7: A strobe taking code 2 (time set) raises `preset_valid_o` for exactly one clock. `preset_o` always shows the register, in the frame layout above.
- R8: A strobe taking code 3 (time read) loads `cnt_i` into the register exactly READ_LAT clocks after the strobe is taken. Shifting then presents the counter frame LSB first on the output.
- R9: `hold_o` is 1 exactly when the latched code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| stb_i | input | 1 | Command strobe, rising edge active, asynchronous |
| cmd_i | input | 3 | Parallel command code |
| sclk_i | input | 1 | Serial clock, rising edge active, asynchronous |
| sdi_i | input | 1 | Serial data in |
| cnt_i | input | 48 | Counter image for time read |
| sdo_pull_o | output | 1 | 1 = pull serial output low, 0 = released |
| cmd_o | output | 4 | Latched effective command code |
| hold_o | output | 1 | Counter hold request |
| preset_o | output | 48 | Shift register contents for presetting counters |
| preset_valid_o | output | 1 | One-clock preset pulse on time set |

## Verification
The assertions assume the host respects the setup and hold rules of the pins:
- chip select and the command lines are steady around each strobe edge;
- serial data is steady around each serial clock rise;
- each strobe and serial clock level lasts several block clocks.

The stimulus meets these rules by construction. Data settles two clocks before each serial clock rise, and every level on the host pins is held for at least four clocks. Frames come from a seeded `$urandom` and are mixed with directed frames at the calendar extremes.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam int PIN_W  = 3;
  localparam int CODE_W = 4;
  localparam logic [PIN_W-1:0] PIN_SERIAL = 3'b111;

  typedef enum logic [CODE_W-1:0] {
    CODE_HOLD  = 4'd0,
    CODE_SHIFT = 4'd1,
    CODE_SET   = 4'd2,
    CODE_READ  = 4'd3
  } ssp_code_e;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssp_edge.sv
module ssp_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s, prev_q;

  ssp_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(d_i), .q_o(s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= s;
  end

  assign rise_o = s & ~prev_q;
endmodule

// File: rtl/ssp_cmd_ctrl.sv
module ssp_cmd_ctrl
  import ssp_pkg::*;
#(
  parameter int READ_LAT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              cs_i,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [CODE_W-1:0] ser_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              hold_o,
  output logic              shift_ok_o,
  output logic              preset_o,
  output logic              load_o
);
  localparam int CW = $clog2(READ_LAT + 2);

  logic [CODE_W-1:0] eff, code_q;
  logic [CW-1:0]     wait_q;
  logic              preset_q;

  assign eff = (pins_i == PIN_SERIAL) ? ser_code_i : {1'b0, pins_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= CODE_HOLD;
      wait_q   <= '0;
      preset_q <= 1'b0;
    end else begin
      preset_q <= take_i && (eff == CODE_SET);
      if (take_i) begin
        code_q <= eff;
        wait_q <= (eff == CODE_READ) ? CW'(READ_LAT) : '0;
      end else if (wait_q != '0) begin
        wait_q <= wait_q - 1'b1;
      end
    end
  end

  assign code_o     = code_q;
  assign hold_o     = (code_q == CODE_HOLD);
  assign preset_o   = preset_q;
  assign load_o     = (wait_q == CW'(1));
  // read mode shifts only after its load has landed
  assign shift_ok_o = cs_i && ((code_q == CODE_SHIFT) ||
                               ((code_q == CODE_READ) && (wait_q == '0)));

  // independent age counter for the read latency check
  logic [CW-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  age_q <= '0;
    else if (take_i)                              age_q <= CW'(1);
    else if (age_q != '0 && age_q <= CW'(READ_LAT)) age_q <= age_q + 1'b1;
  end

  p_strobe_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(code_q));
  p_set_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_q |=> !preset_q);
  p_read_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (age_q == CW'(READ_LAT)) && (code_q == CODE_READ));
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int FW = 48
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          sdi_i,
  input  logic          load_i,
  input  logic [FW-1:0] par_i,
  output logic [FW-1:0] q_o
);
  logic [FW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= {sdi_i, q[FW-1:1]};
  end

  assign q_o = q;

  p_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i && !load_i |=> (q[FW-2:0] == $past(q[FW-1:1])) && (q[FW-1] == $past(sdi_i)));
  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i && !load_i |=> $stable(q));
  p_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q == $past(par_i));
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port
  import ssp_pkg::*;
#(
  parameter int FRAME_W     = 48,
  parameter int READ_LAT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                stb_i,
  input  logic [2:0]          cmd_i,
  input  logic                sclk_i,
  input  logic                sdi_i,
  input  logic [FRAME_W-1:0]  cnt_i,
  output logic                sdo_pull_o,
  output logic [3:0]          cmd_o,
  output logic                hold_o,
  output logic [FRAME_W-1:0]  preset_o,
  output logic                preset_valid_o
);
  localparam int LVL_W = PIN_W + 2;

  logic [LVL_W-1:0] lvl_s;
  logic             cs_s, sdi_s;
  logic [PIN_W-1:0] pins_s;
  logic [1:0]       rise;
  logic             stb_rise, sclk_rise;
  logic             shift_ok, load, take;
  logic [FRAME_W-1:0] sr;

  ssp_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cmd_i, sdi_i, cs_i}), .q_o(lvl_s)
  );
  assign {pins_s, sdi_s, cs_s} = lvl_s;

  ssp_edge #(.W(2), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({stb_i, sclk_i}), .rise_o(rise)
  );
  assign {stb_rise, sclk_rise} = rise;
  assign take = stb_rise && cs_s;

  ssp_cmd_ctrl #(.READ_LAT(READ_LAT)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .take_i(take), .cs_i(cs_s), .pins_i(pins_s),
    .ser_code_i(sr[FRAME_W-1 -: CODE_W]),
    .code_o(cmd_o), .hold_o(hold_o), .shift_ok_o(shift_ok),
    .preset_o(preset_valid_o), .load_o(load)
  );

  ssp_shifter #(.FW(FRAME_W)) u_sr (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .shift_i(sclk_rise && shift_ok), .sdi_i(sdi_s),
    .load_i(load), .par_i(cnt_i), .q_o(sr)
  );

  assign preset_o   = sr;
  assign sdo_pull_o = shift_ok && !sr[0];

  p_cs_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_pull_o |-> cs_s);
  p_no_shift_cs_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s && !load |=> $stable(sr));
endmodule

// File: tb/rtc_serial_port_bench.sv
module rtc_serial_port_bench;
  localparam int FW = 48;

  logic clk = 0, rst_n = 0;
  logic cs = 0, stb = 0, sclk = 0, sdi = 0;
  logic [2:0] cmd = 0;
  logic [FW-1:0] cnt = 0;
  logic sdo_pull, hold, pv;
  logic [3:0] cmd_o;
  logic [FW-1:0] preset;

  int checks = 0, fails = 0, pulses = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_serial_port u_rtc_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .stb_i(stb), .cmd_i(cmd),
    .sclk_i(sclk), .sdi_i(sdi), .cnt_i(cnt), .sdo_pull_o(sdo_pull),
    .cmd_o(cmd_o), .hold_o(hold), .preset_o(preset), .preset_valid_o(pv)
  );

  always @(posedge clk) if (rst_n && pv) pulses++;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [2:0] c);
    cmd = c; cyc(4); stb = 1; cyc(5); stb = 0; cyc(6);
  endtask

  task automatic send_bit(input logic b);
    sdi = b; cyc(2); sclk = 1; cyc(4); sclk = 0; cyc(2);
  endtask

  task automatic shift_in(input logic [FW-1:0] f);
    for (int i = 0; i < FW; i++) send_bit(f[i]);
  endtask

  task automatic shift_out(output logic [FW-1:0] f);
    for (int i = 0; i < FW; i++) begin
      f[i] = !sdo_pull;
      send_bit(1'b0);
    end
  endtask

  function automatic logic [FW-1:0] mk(input logic [7:0] s, mi, h, d,
                                       input logic [3:0] wd, mo, input logic [7:0] y);
    return {y, mo, wd, d, h, mi, s};
  endfunction

  function automatic logic [FW-1:0] rnd48();
    return {16'($urandom), 32'($urandom)};
  endfunction

  initial begin
    logic [FW-1:0] f, g, held;
    int p0;
    void'($urandom(32'h5eed));
    cyc(3);
    // R1 reset state
    check(cmd_o == 0, "R1 cmd", 64'(cmd_o), 0);
    check(hold == 1, "R1 hold", 64'(hold), 1);
    check(pv == 0 && sdo_pull == 0, "R1 outputs", {pv, sdo_pull}, 0);
    check(preset == 0, "R1 preset", 64'(preset), 0);
    rst_n = 1; cyc(3);

    // R2/R9: shift command
    cs = 1; strobe(3'd1);
    check(cmd_o == 4'd1, "R2 cmd latch", 64'(cmd_o), 1);
    check(hold == 0, "R9 hold low", 64'(hold), 0);

    // R4/R7 directed frame
    f = mk(8'h59, 8'h30, 8'h23, 8'h31, 4'h6, 4'hC, 8'h99);
    shift_in(f);
    check(preset == f, "R4 shift in", 64'(preset), 64'(f));
    check(sdo_pull == !f[0], "R6 pull vs bit0", 64'(sdo_pull), 64'(!f[0]));
    p0 = pulses; strobe(3'd2);
    check(pulses == p0 + 1, "R7 one-cycle pulse", 64'(pulses - p0), 1);
    check(preset[7:0] == 8'h59 && preset[47:40] == 8'h99, "R7 layout", 64'(preset), 64'(f));
    check(sdo_pull == 0, "R6 released in set", 64'(sdo_pull), 0);

    // R5: set mode ignores clocks
    held = preset;
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    check(preset == held, "R5 set mode", 64'(preset), 64'(held));
    strobe(3'd0);
    check(hold == 1 && cmd_o == 0, "R9 hold high", {hold, cmd_o}, 64'h10);
    for (int i = 0; i < 5; i++) send_bit(~i[0]);
    check(preset == held, "R5 hold mode", 64'(preset), 64'(held));
    strobe(3'd5);
    check(cmd_o == 4'd5 && hold == 0, "R2 code 5", 64'(cmd_o), 5);
    send_bit(1'b1);
    check(preset == held, "R5 other code", 64'(preset), 64'(held));

    // R2: strobe with cs low ignored
    cs = 0; cyc(4); strobe(3'd1);
    check(cmd_o == 4'd5, "R2 cs low strobe", 64'(cmd_o), 5);
    cs = 1; cyc(4); strobe(3'd1); cs = 0; cyc(4);
    check(sdo_pull == 0, "R6 cs low released", 64'(sdo_pull), 0);
    for (int i = 0; i < 6; i++) send_bit(1'b1);
    check(preset == held, "R5 cs low clocks", 64'(preset), 64'(held));
    cs = 1; cyc(4);

    // R3: serial-supplied code
    f = rnd48(); f[47:44] = 4'hA; shift_in(f);
    strobe(3'd7);
    check(cmd_o == 4'hA && hold == 0, "R3 serial code A", 64'(cmd_o), 64'hA);
    strobe(3'd1);
    f = rnd48(); f[47:44] = 4'h0; shift_in(f);
    strobe(3'd7);
    check(cmd_o == 4'h0 && hold == 1, "R3 serial code 0", {hold, cmd_o}, 64'h10);

    // R8: time read, directed extremes then random
    for (int k = 0; k < 6; k++) begin
      cnt = (k == 0) ? mk(8'h59, 8'h59, 8'h23, 8'h31, 4'h6, 4'hC, 8'h99)
          : (k == 1) ? mk(8'h00, 8'h00, 8'h00, 8'h01, 4'h0, 4'h1, 8'h00) : rnd48();
      strobe(3'd3); cyc(8);
      check(preset == cnt, "R8 read load", 64'(preset), 64'(cnt));
      shift_out(g);
      check(g == cnt, "R8 read out", 64'(g), 64'(cnt));
    end

    // R4/R7 random frames
    for (int k = 0; k < 8; k++) begin
      f = rnd48();
      strobe(3'd1); shift_in(f);
      check(preset == f, "R4 random shift", 64'(preset), 64'(f));
      p0 = pulses; strobe(3'd2);
      check(pulses == p0 + 1 && preset == f, "R7 random set", 64'(preset), 64'(f));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule